// File: doc/BRIEF.md
# Blocking Dual-Port Request Forwarder

This block sits between two requester ports, one carrying instruction fetches and one carrying data accesses, and a single memory-side port. It lets exactly one transaction be in flight at a time across both requesters: an accepted request is passed on to memory, and the block stays blocked until the matching response comes back. It then steers that response to the requester that issued the request.

Each channel uses a one-cycle offer that the receiver accepts or rejects in the same cycle. A rejected sender keeps its item and may offer it again only after the receiver sends a one-cycle retry pulse. The block follows the same rule as a sender. A request or response that it cannot deliver waits in a holding register until a retry arrives. When it rejects a requester, it records a retry-needed flag for that port, and it later pays that flag back with a retry pulse once it is free again.

Top module: `blocking_fwd`

## Requirements
- R1: From the cycle after a request is accepted until the cycle after its memory response is accepted, every requester offer is rejected in the cycle it is made (its accept output stays low).
- R2: A request accepted in cycle t is offered to memory in cycle t+1 with the same address and command. Requester offers are accepted combinationally in the cycle they appear while the block is unblocked.
- R3: When both requester ports offer in the same unblocked cycle, the data port is accepted and the instruction port is rejected.
- R4: A rejected requester offer is not stored and never reaches memory. The port's retry-needed flag is set instead.
- R5: If memory rejects a forwarded request, that request is not offered again until memory pulses its request-retry. It is re-offered, unchanged, in the cycle after that pulse. A holding register is never loaded while it is occupied.
- R6: A memory response is accepted only while a request is outstanding. A response offered while unblocked gets no accept and produces no requester response.
- R7: A memory response accepted in cycle c is offered in cycle c+1 on the instruction port if its request came from the instruction port, and on the data port otherwise. In cycle c+1 the block is already unblocked and can accept a new request.
- R8: If a requester rejects its response, the response is held and offered again, unchanged, in the cycle after that port's response-retry pulse.
- R9: In the cycle a response is first offered (c+1), each port pulses its request-retry for exactly one cycle if its retry-needed flag is set and its own response is not left held at the end of that cycle. The pulse clears the flag.
- R10: A request-retry pulse is only given in a cycle in which the block can accept a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insReqOffer | input | 1 | Instruction port offers a request |
| insReqAddr | input | ADDR_W | Instruction request address |
| insReqCmd | input | CMD_W | Instruction request command (opaque) |
| insReqAccept | output | 1 | Instruction request accepted this cycle |
| insReqRetry | output | 1 | Instruction port may re-offer |
| insRspOffer | output | 1 | Response offered on instruction port |
| insRspAddr | output | ADDR_W | Instruction response address |
| insRspCmd | output | CMD_W | Instruction response command |
| insRspAccept | input | 1 | Instruction port accepts the response |
| insRspRetry | input | 1 | Instruction port ready for a held response |
| datReqOffer | input | 1 | Data port offers a request |
| datReqAddr | input | ADDR_W | Data request address |
| datReqCmd | input | CMD_W | Data request command (opaque) |
| datReqAccept | output | 1 | Data request accepted this cycle |
| datReqRetry | output | 1 | Data port may re-offer |
| datRspOffer | output | 1 | Response offered on data port |
| datRspAddr | output | ADDR_W | Data response address |
| datRspCmd | output | CMD_W | Data response command |
| datRspAccept | input | 1 | Data port accepts the response |
| datRspRetry | input | 1 | Data port ready for a held response |
| memReqOffer | output | 1 | Request offered to memory |
| memReqAddr | output | ADDR_W | Memory request address |
| memReqCmd | output | CMD_W | Memory request command |
| memReqAccept | input | 1 | Memory accepts the request |
| memReqRetry | input | 1 | Memory ready for a held request |
| memRspOffer | input | 1 | Memory offers a response |
| memRspAddr | input | ADDR_W | Memory response address |
| memRspCmd | input | CMD_W | Memory response command |
| memRspAccept | output | 1 | Block accepts the memory response |

## Verification
Accepts for requester offers and memory responses are due in the same cycle as the offer. A forwarded request is due one cycle after its acceptance, and a routed response together with any request-retry pulses is due one cycle after the memory response is accepted. Re-offers from a holding register are due one cycle after the matching retry pulse. The bench drives inputs just after the falling edge and checks combinational accepts and retries a moment later, in the same cycle. A scoreboard monitor that samples every cycle at that point compares each offer on the memory and requester sides with the head of its expected queue. It pops an entry only when the offer is accepted, so an early, late, duplicated or misrouted item is counted as a failure.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int PORT_DAT  = 0;
  localparam int PORT_INS  = 1;
  localparam int NUM_PORTS = 2;

  typedef enum logic [1:0] {
    Q_EMPTY = 2'd0,
    Q_SEND  = 2'd1,
    Q_WAIT  = 2'd2
  } qState_t;

  typedef struct packed {
    logic                 loadReq;
    logic                 selIns;
    logic [NUM_PORTS-1:0] loadRsp;
  } fwdStrobe_t;
endpackage

// File: rtl/fwd_outq.sv
module fwd_outq
  import fwd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic taken,
  input  logic retry,
  output logic offer,
  output logic occupied
);
  qState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= Q_EMPTY;
    end else begin
      case (state)
        Q_EMPTY: if (load) state <= Q_SEND;
        Q_SEND:  state <= taken ? Q_EMPTY : Q_WAIT;
        Q_WAIT:  if (retry) state <= Q_SEND;
        default: state <= Q_EMPTY;
      endcase
    end
  end

  assign offer    = (state == Q_SEND);
  assign occupied = (state != Q_EMPTY);

  assert_hold_free_R5: assert property (@(posedge clk) disable iff (!rstN)
    load |-> state == Q_EMPTY);
endmodule

// File: rtl/fwd_dpath.sv
module fwd_dpath
  import fwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 2,
  localparam int ITEM_W = ADDR_W + CMD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fwdStrobe_t           strobe,
  input  logic [ITEM_W-1:0]    datItem,
  input  logic [ITEM_W-1:0]    insItem,
  input  logic [ITEM_W-1:0]    memRspItem,
  output logic [ITEM_W-1:0]    memReqItem,
  output logic [ITEM_W-1:0]    rspItem [NUM_PORTS],
  output logic                 fetchTag
);
  logic [ITEM_W-1:0] reqHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqHold  <= '0;
      fetchTag <= 1'b0;
    end else if (strobe.loadReq) begin
      reqHold  <= strobe.selIns ? insItem : datItem;
      fetchTag <= strobe.selIns;
    end
  end

  assign memReqItem = reqHold;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gRspHold
    logic [ITEM_W-1:0] rspHold;
    always_ff @(posedge clk) begin
      if (!rstN)                  rspHold <= '0;
      else if (strobe.loadRsp[p]) rspHold <= memRspItem;
    end
    assign rspItem[p] = rspHold;
  end
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] reqOffer,
  output logic [NUM_PORTS-1:0] reqAccept,
  output logic [NUM_PORTS-1:0] reqRetry,
  output logic [NUM_PORTS-1:0] rspOffer,
  input  logic [NUM_PORTS-1:0] rspAccept,
  input  logic [NUM_PORTS-1:0] rspRetry,
  output logic                 memReqOffer,
  input  logic                 memReqAccept,
  input  logic                 memReqRetry,
  input  logic                 memRspOffer,
  output logic                 memRspAccept,
  input  logic                 fetchTag,
  output fwdStrobe_t           strobe
);
  logic                 blocked;
  logic                 rspSeen;
  logic                 memOcc;
  logic [NUM_PORTS-1:0] rspOcc;
  logic [NUM_PORTS-1:0] retryFlag;
  logic [NUM_PORTS-1:0] rejected;

  // Lowest index wins: data port (index 0) beats instruction port.
  always_comb begin
    logic granted;
    granted   = 1'b0;
    reqAccept = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (!blocked && reqOffer[p] && !granted) begin
        reqAccept[p] = 1'b1;
        granted      = 1'b1;
      end
    end
  end

  assign rejected     = reqOffer & ~reqAccept;
  assign memRspAccept = memRspOffer && blocked;

  always_comb begin
    strobe                   = '0;
    strobe.loadReq           = |reqAccept;
    strobe.selIns            = reqAccept[PORT_INS];
    strobe.loadRsp[PORT_INS] = memRspAccept && fetchTag;
    strobe.loadRsp[PORT_DAT] = memRspAccept && !fetchTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blocked <= 1'b0;
      rspSeen <= 1'b0;
    end else begin
      rspSeen <= memRspAccept;
      if (strobe.loadReq)   blocked <= 1'b1;
      else if (memRspAccept) blocked <= 1'b0;
    end
  end

  fwd_outq uMemQ (
    .clk      (clk),
    .rstN     (rstN),
    .load     (strobe.loadReq),
    .taken    (memReqAccept),
    .retry    (memReqRetry),
    .offer    (memReqOffer),
    .occupied (memOcc)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    logic rspStuck;

    fwd_outq uRspQ (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strobe.loadRsp[p]),
      .taken    (rspAccept[p]),
      .retry    (rspRetry[p]),
      .offer    (rspOffer[p]),
      .occupied (rspOcc[p])
    );

    assign rspStuck    = rspOcc[p] && !(rspOffer[p] && rspAccept[p]);
    assign reqRetry[p] = retryFlag[p] && rspSeen && !blocked && !rspStuck;

    always_ff @(posedge clk) begin
      if (!rstN)            retryFlag[p] <= 1'b0;
      else if (rejected[p]) retryFlag[p] <= 1'b1;
      else if (reqRetry[p]) retryFlag[p] <= 1'b0;
    end

    assert_retry_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
      reqRetry[p] |-> !blocked && !memOcc);
  end

  assert_single_flight_R1: assert property (@(posedge clk) disable iff (!rstN)
    (|reqAccept) |-> !memOcc && !blocked);

  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqAccept));

  assert_route_ins_R7: assert property (@(posedge clk) disable iff (!rstN)
    memRspAccept && fetchTag |=> rspOffer[PORT_INS] && !blocked);

  assert_route_dat_R7: assert property (@(posedge clk) disable iff (!rstN)
    memRspAccept && !fetchTag |=> rspOffer[PORT_DAT] && !blocked);
endmodule

// File: rtl/blocking_fwd.sv
module blocking_fwd
  import fwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insReqOffer,
  input  logic [ADDR_W-1:0] insReqAddr,
  input  logic [CMD_W-1:0]  insReqCmd,
  output logic              insReqAccept,
  output logic              insReqRetry,
  output logic              insRspOffer,
  output logic [ADDR_W-1:0] insRspAddr,
  output logic [CMD_W-1:0]  insRspCmd,
  input  logic              insRspAccept,
  input  logic              insRspRetry,
  input  logic              datReqOffer,
  input  logic [ADDR_W-1:0] datReqAddr,
  input  logic [CMD_W-1:0]  datReqCmd,
  output logic              datReqAccept,
  output logic              datReqRetry,
  output logic              datRspOffer,
  output logic [ADDR_W-1:0] datRspAddr,
  output logic [CMD_W-1:0]  datRspCmd,
  input  logic              datRspAccept,
  input  logic              datRspRetry,
  output logic              memReqOffer,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [CMD_W-1:0]  memReqCmd,
  input  logic              memReqAccept,
  input  logic              memReqRetry,
  input  logic              memRspOffer,
  input  logic [ADDR_W-1:0] memRspAddr,
  input  logic [CMD_W-1:0]  memRspCmd,
  output logic              memRspAccept
);
  localparam int ITEM_W = ADDR_W + CMD_W;

  fwdStrobe_t           strobe;
  logic                 fetchTag;
  logic [NUM_PORTS-1:0] reqOffer, reqAccept, reqRetry;
  logic [NUM_PORTS-1:0] rspOffer, rspAccept, rspRetry;
  logic [ITEM_W-1:0]    memReqItem;
  logic [ITEM_W-1:0]    rspItem [NUM_PORTS];

  assign reqOffer[PORT_DAT]  = datReqOffer;
  assign reqOffer[PORT_INS]  = insReqOffer;
  assign rspAccept[PORT_DAT] = datRspAccept;
  assign rspAccept[PORT_INS] = insRspAccept;
  assign rspRetry[PORT_DAT]  = datRspRetry;
  assign rspRetry[PORT_INS]  = insRspRetry;

  assign datReqAccept = reqAccept[PORT_DAT];
  assign insReqAccept = reqAccept[PORT_INS];
  assign datReqRetry  = reqRetry[PORT_DAT];
  assign insReqRetry  = reqRetry[PORT_INS];
  assign datRspOffer  = rspOffer[PORT_DAT];
  assign insRspOffer  = rspOffer[PORT_INS];
  assign {datRspAddr, datRspCmd} = rspItem[PORT_DAT];
  assign {insRspAddr, insRspCmd} = rspItem[PORT_INS];
  assign {memReqAddr, memReqCmd} = memReqItem;

  fwd_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqOffer     (reqOffer),
    .reqAccept    (reqAccept),
    .reqRetry     (reqRetry),
    .rspOffer     (rspOffer),
    .rspAccept    (rspAccept),
    .rspRetry     (rspRetry),
    .memReqOffer  (memReqOffer),
    .memReqAccept (memReqAccept),
    .memReqRetry  (memReqRetry),
    .memRspOffer  (memRspOffer),
    .memRspAccept (memRspAccept),
    .fetchTag     (fetchTag),
    .strobe       (strobe)
  );

  fwd_dpath #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .datItem    ({datReqAddr, datReqCmd}),
    .insItem    ({insReqAddr, insReqCmd}),
    .memRspItem ({memRspAddr, memRspCmd}),
    .memReqItem (memReqItem),
    .rspItem    (rspItem),
    .fetchTag   (fetchTag)
  );
endmodule

// File: tb/blocking_fwd_tb_top.sv
module blocking_fwd_tb_top;
  localparam int AW = 32;
  localparam int CW = 2;
  localparam int CLK_P = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insReqOffer, insReqAccept, insReqRetry, insRspOffer, insRspAccept, insRspRetry;
  logic datReqOffer, datReqAccept, datReqRetry, datRspOffer, datRspAccept, datRspRetry;
  logic memReqOffer, memReqAccept, memReqRetry, memRspOffer, memRspAccept;
  logic [AW-1:0] insReqAddr, insRspAddr, datReqAddr, datRspAddr, memReqAddr, memRspAddr;
  logic [CW-1:0] insReqCmd, insRspCmd, datReqCmd, datRspCmd, memReqCmd, memRspCmd;

  int testCnt = 0;
  int failCnt = 0;
  logic [AW+CW-1:0] memQ[$];
  logic [AW+CW:0]   rspQ[$];   // {port(1=ins), addr, cmd}

  always #(CLK_P/2) clk = ~clk;

  blocking_fwd #(.ADDR_W(AW), .CMD_W(CW)) dut_i (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    insReqOffer = 0; insRspAccept = 0; insRspRetry = 0;
    datReqOffer = 0; datRspAccept = 0; datRspRetry = 0;
    memReqAccept = 0; memReqRetry = 0; memRspOffer = 0;
  endtask

  task automatic offerDat(logic [AW-1:0] a, logic [CW-1:0] c);
    datReqOffer = 1; datReqAddr = a; datReqCmd = c;
  endtask
  task automatic offerIns(logic [AW-1:0] a, logic [CW-1:0] c);
    insReqOffer = 1; insReqAddr = a; insReqCmd = c;
  endtask
  task automatic memRsp(logic [AW-1:0] a, logic [CW-1:0] c, bit ins);
    memRspOffer = 1; memRspAddr = a; memRspCmd = c;
    rspQ.push_back({ins, a, c});
  endtask

  // Scoreboard monitor: compares every offer with the queue head, pops on accept.
  always begin
    @(negedge clk);
    #2;
    if (rstN) begin
      if (memReqOffer) begin
        if (memQ.size() == 0) chk("R2 unexpected memory request", {memReqAddr, memReqCmd}, 0);
        else begin
          chk("R2 memory request item", {memReqAddr, memReqCmd}, memQ[0]);
          if (memReqAccept) void'(memQ.pop_front());
        end
      end
      if (datRspOffer || insRspOffer) begin
        if (rspQ.size() == 0) chk("R7 unexpected response", 1, 0);
        else if (insRspOffer) begin
          chk("R7 instruction response item", {1'b1, insRspAddr, insRspCmd}, rspQ[0]);
          if (insRspAccept) void'(rspQ.pop_front());
        end else begin
          chk("R7 data response item", {1'b0, datRspAddr, datRspCmd}, rspQ[0]);
          if (datRspAccept) void'(rspQ.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    insReqAddr = 0; insReqCmd = 0; datReqAddr = 0; datReqCmd = 0;
    memRspAddr = 0; memRspCmd = 0;
    tick();
    tick();
    tick();
    rstN = 1;
    tick(); #1;
    chk("reset outputs", {insReqRetry, datReqRetry, insRspOffer, datRspOffer, memReqOffer}, 0);

    // Plain data transaction
    tick(); offerDat(32'h100, 2'd1); #1;
    chk("R2 data request accepted", datReqAccept, 1);
    memQ.push_back({32'h100, 2'd1});
    tick(); memReqAccept = 1; #1;
    chk("R2 forwarded next cycle", memReqOffer, 1);
    tick(); offerIns(32'h200, 2'd0); offerDat(32'h104, 2'd1); #1;
    chk("R1 both rejected while blocked", {insReqAccept, datReqAccept}, 0);
    chk("R4 rejected request not forwarded", memReqOffer, 0);
    tick(); memRsp(32'h100, 2'd2, 0); #1;
    chk("R6 response accepted while blocked", memRspAccept, 1);
    tick(); datRspAccept = 1; offerDat(32'h108, 2'd1); #1;
    chk("R7 routed to data port", {insRspOffer, datRspOffer}, 2'b01);
    chk("R7 unblocked in response cycle", datReqAccept, 1);
    chk("R9 retry pulses on both flagged ports", {insReqRetry, datReqRetry}, 2'b11);
    memQ.push_back({32'h108, 2'd1});
    tick(); memReqAccept = 1; #1;
    chk("R9 retry is a single pulse", {insReqRetry, datReqRetry}, 0);
    tick(); memRsp(32'h108, 2'd3, 0); #1;
    tick(); datRspAccept = 1; #1;
    chk("R9 no retry with flags clear", {insReqRetry, datReqRetry}, 0);

    // Stray memory response
    tick(); memRspOffer = 1; memRspAddr = 32'hDEAD; memRspCmd = 2'd1; #1;
    chk("R6 stray response not accepted", memRspAccept, 0);
    tick(); #1;
    chk("R6 stray response not routed", {insRspOffer, datRspOffer}, 0);

    // Instruction fetch with memory reject and response reject
    tick(); offerIns(32'h300, 2'd0); #1;
    chk("R2 instruction request accepted", insReqAccept, 1);
    memQ.push_back({32'h300, 2'd0});
    tick(); #1;
    chk("R5 first memory offer", memReqOffer, 1);
    tick(); offerIns(32'h304, 2'd0); offerDat(32'h400, 2'd1); #1;
    chk("R1 rejected during memory reject", {insReqAccept, datReqAccept}, 0);
    chk("R5 held request not re-offered", memReqOffer, 0);
    tick(); #1;
    chk("R5 still held without retry", memReqOffer, 0);
    tick(); memReqRetry = 1; #1;
    chk("R5 not offered in retry cycle", memReqOffer, 0);
    tick(); memReqAccept = 1; #1;
    chk("R5 re-offered after retry", memReqOffer, 1);
    tick(); memRsp(32'h300, 2'd2, 1); #1;
    chk("R6 response accepted", memRspAccept, 1);
    tick(); #1;
    chk("R7 routed to instruction port", {insRspOffer, datRspOffer}, 2'b10);
    chk("R9 retry only where response not held", {insReqRetry, datReqRetry}, 2'b01);
    tick(); #1;
    chk("R8 held response not re-offered", insRspOffer, 0);
    tick(); insRspRetry = 1; #1;
    chk("R8 not offered in retry cycle", insRspOffer, 0);
    tick(); insRspAccept = 1; #1;
    chk("R8 re-offered after retry", insRspOffer, 1);
    chk("R9 no retry without a response", insReqRetry, 0);

    // Tie: data wins
    tick(); offerDat(32'h500, 2'd1); offerIns(32'h600, 2'd0); #1;
    chk("R3 tie resolved to data", {insReqAccept, datReqAccept}, 2'b01);
    memQ.push_back({32'h500, 2'd1});
    tick(); memReqAccept = 1; #1;
    tick(); memRsp(32'h500, 2'd2, 0); #1;
    tick(); datRspAccept = 1; #1;
    chk("R4 instruction retry owed after rejects", {insReqRetry, datReqRetry}, 2'b10);
    tick(); offerIns(32'h304, 2'd0); #1;
    chk("R10 re-offer after retry accepted", insReqAccept, 1);
    memQ.push_back({32'h304, 2'd0});
    tick(); memReqAccept = 1; #1;
    tick(); memRsp(32'h304, 2'd0, 1); #1;
    tick(); insRspAccept = 1; #1;
    chk("R7 fetch response on instruction port", insRspOffer, 1);
    tick(); tick(); #1;
    chk("R2 memory queue drained", memQ.size(), 0);
    chk("R7 response queue drained", rspQ.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule